// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout

The block is a register-mapped watchdog with two independent 32-bit down-counters. The main counter guards the system. When it runs out it raises a level interrupt and can request a system reset. The second counter is loaded by software with a smaller value, so it runs out first and raises an early-warning interrupt. Software keeps the system alive by rewriting the main counter before it reaches zero.

Each counter takes its decrement tick from one of two sources. The first is a free-running prescaler that divides the core clock by a power of two set in the control register. The second is an externally supplied reference tick, given as an enable input. Expiry events are kept as sticky flags in a status register. A reset request comes out only when three conditions all hold: reset output is enabled in one register, it is not masked in another register, and the main counter is running. The reset request is a pulse of fixed length.

Register access is a single-cycle write port. Read data is registered and is valid one cycle after the address is presented.

Top module: `wdog_pretmo`

## Requirements
- R1: After reset, every register reads zero. Both counters are stopped, both interrupts are low, and the reset request is low.
- R2: The register map is: control 0x00, status 0x04, pretimeout count 0x1C, watchdog count 0x34, reset enable 0x40 (bit 8), reset mask 0x44 (bit 10). The control fields are: bit 2 pretimeout enable, bit 8 watchdog enable, bit 10 watchdog reference-tick select, bit 12 pretimeout reference-tick select, bits 19:16 prescaler exponent. Bits that are not defined read 0, and unmapped addresses read 0. rdata shows the addressed register as it stood at the previous clock edge.
- R3: While a counter is enabled, it decrements by exactly one per selected tick. While it is disabled, it keeps its value. Any 32-bit value up to 0xFFFFFFFF can be loaded and read back.
- R4: A counter that ticks from 1 to 0 expires. At expiry it sets its sticky status flag (status bit 31 for the watchdog, status bit 8 for the pretimeout). It then stays at zero. Each interrupt output follows its flag.
- R5: A status flag is cleared only by writing 0 to its bit. Writing 1 to the bit leaves the flag unchanged.
- R6: The pretimeout counter has its own load value, enable, flag and interrupt. Its expiry does not affect the watchdog counter or the watchdog flag.
- R7: Watchdog expiry requests a reset only if reset enable bit 8 is 1, reset mask bit 10 is 0, and the watchdog is enabled.
- R8: A permitted expiry gives exactly one reset-request pulse of 16 clock cycles. A counter that stays at zero gives no further pulse.
- R9: If a counter register is written in the same cycle as a tick, the written value is stored and the decrement is lost.
- R10: The prescaled tick occurs once every 2^E clock cycles, where E is the exponent field. E = 0 ticks every cycle, and E = 5 divides by 32.
- R11: When its select bit is set, each counter counts only ref_tick pulses. When the bit is clear, it counts only prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Fixed reference tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wd_irq | output | 1 | Watchdog expired level |
| pre_irq | output | 1 | Pretimeout expired level |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench uses the default parameters: 32-bit counters, a 4-bit prescaler exponent and a 16-cycle reset pulse. Selecting the reference tick gives the bench control of every decrement, one cycle at a time. This lets it step each counter through all load values from 1 to 8 and check the count and the interrupt after every tick. The prescaler is checked by reading a counter twice, a known number of cycles apart. With exponents 0 and 5 the difference must be exactly cycles / 2^E, whatever the prescaler phase. All four combinations of reset enable and reset mask are exercised, and the reset pulse length is counted cycle by cycle.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_PRE   = 8'h1C;
  localparam logic [7:0] OFF_WD    = 8'h34;
  localparam logic [7:0] OFF_RSTEN = 8'h40;
  localparam logic [7:0] OFF_RSTMK = 8'h44;

  localparam int B_PRE_EN  = 2;
  localparam int B_WD_EN   = 8;
  localparam int B_WD_REF  = 10;
  localparam int B_PRE_REF = 12;
  localparam int B_EXP_LO  = 16;
  localparam int B_WD_FLAG = 31;
  localparam int B_PRE_FLG = 8;
  localparam int B_RSTEN   = 8;
  localparam int B_RSTMK   = 10;

  localparam int CH_WD  = 0;
  localparam int CH_PRE = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/wdp_prescale.sv
module wdp_prescale #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << exp_sel);
  assign tick = (div_q & mask) == mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdp_downcnt.sv
module wdp_downcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = en && tick && !load && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)                            count <= '0;
    else if (load)                      count <= load_val;
    else if (en && tick && count != '0) count <= count - 1'b1;
  end

  // R4: an empty counter stays empty until reloaded
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load) |=> count == '0);
  // R3: disabled counter keeps its value
  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(count));
  // R9: a write always lands, tick or not
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
endmodule

// File: rtl/wdp_rstpulse.sv
module wdp_rstpulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (fire && !pulse) begin
      pulse  <= 1'b1;
      left_q <= LW'(LEN - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      pulse  <= 1'b0;
    end
  end

  // R8: a permitted expiry starts the pulse on the next edge
  p_start_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse);
endmodule

// File: rtl/wdog_pretmo.sv
module wdog_pretmo
  import wdp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int EXP_W     = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wd_irq,
  output logic              pre_irq,
  output logic              rst_req
);
  logic             wd_en_q, pre_en_q, wd_ref_q, pre_ref_q;
  logic [EXP_W-1:0] exp_q;
  logic             rsten_q, rstmk_q;
  logic             wd_flag_q, pre_flag_q;
  logic             psc_tick;

  logic [N_CH-1:0]  ch_en, ch_tick, ch_load, ch_exp;
  logic [DATA_W-1:0] ch_cnt [N_CH];

  logic wr_ctrl, wr_stat, wr_rsten, wr_rstmk, permit;

  assign wr_ctrl  = wr_en && addr == ADDR_W'(OFF_CTRL);
  assign wr_stat  = wr_en && addr == ADDR_W'(OFF_STAT);
  assign wr_rsten = wr_en && addr == ADDR_W'(OFF_RSTEN);
  assign wr_rstmk = wr_en && addr == ADDR_W'(OFF_RSTMK);

  wdp_prescale #(.EXP_W(EXP_W)) u_psc (
    .clk(clk), .rst(rst), .exp_sel(exp_q), .tick(psc_tick)
  );

  assign ch_en[CH_WD]    = wd_en_q;
  assign ch_en[CH_PRE]   = pre_en_q;
  assign ch_tick[CH_WD]  = wd_ref_q  ? ref_tick : psc_tick;
  assign ch_tick[CH_PRE] = pre_ref_q ? ref_tick : psc_tick;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [7:0] OFF = (g == CH_WD) ? OFF_WD : OFF_PRE;
    assign ch_load[g] = wr_en && addr == ADDR_W'(OFF);
    wdp_downcnt #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .en(ch_en[g]), .tick(ch_tick[g]),
      .load(ch_load[g]), .load_val(wdata),
      .count(ch_cnt[g]), .expire(ch_exp[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_en_q <= 1'b0; pre_en_q <= 1'b0; wd_ref_q <= 1'b0; pre_ref_q <= 1'b0;
      exp_q   <= '0;
      rsten_q <= 1'b0; rstmk_q  <= 1'b0;
      wd_flag_q <= 1'b0; pre_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pre_en_q  <= wdata[B_PRE_EN];
        wd_en_q   <= wdata[B_WD_EN];
        wd_ref_q  <= wdata[B_WD_REF];
        pre_ref_q <= wdata[B_PRE_REF];
        exp_q     <= wdata[B_EXP_LO +: EXP_W];
      end
      if (wr_rsten) rsten_q <= wdata[B_RSTEN];
      if (wr_rstmk) rstmk_q <= wdata[B_RSTMK];
      wd_flag_q  <= ch_exp[CH_WD]  | (wd_flag_q  & ~(wr_stat & ~wdata[B_WD_FLAG]));
      pre_flag_q <= ch_exp[CH_PRE] | (pre_flag_q & ~(wr_stat & ~wdata[B_PRE_FLG]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        ADDR_W'(OFF_CTRL): begin
          rdata[B_PRE_EN]            <= pre_en_q;
          rdata[B_WD_EN]             <= wd_en_q;
          rdata[B_WD_REF]            <= wd_ref_q;
          rdata[B_PRE_REF]           <= pre_ref_q;
          rdata[B_EXP_LO +: EXP_W]   <= exp_q;
        end
        ADDR_W'(OFF_STAT): begin
          rdata[B_WD_FLAG] <= wd_flag_q;
          rdata[B_PRE_FLG] <= pre_flag_q;
        end
        ADDR_W'(OFF_PRE):   rdata <= ch_cnt[CH_PRE];
        ADDR_W'(OFF_WD):    rdata <= ch_cnt[CH_WD];
        ADDR_W'(OFF_RSTEN): rdata[B_RSTEN] <= rsten_q;
        ADDR_W'(OFF_RSTMK): rdata[B_RSTMK] <= rstmk_q;
        default:            rdata <= '0;
      endcase
    end
  end

  assign permit = rsten_q && !rstmk_q && wd_en_q;

  wdp_rstpulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(ch_exp[CH_WD] && permit), .pulse(rst_req)
  );

  assign wd_irq  = wd_flag_q;
  assign pre_irq = pre_flag_q;

  // R7: a reset request only starts while reset is permitted
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(rsten_q && !rstmk_q && wd_en_q));
  // R4: the watchdog flag rises together with the count reaching zero
  p_flag_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_flag_q) |-> ch_cnt[CH_WD] == '0);
endmodule

// File: tb/wdog_pretmo_bench.sv
module wdog_pretmo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wd_irq, pre_irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdog_pretmo u_wdog_pretmo (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wd_irq(wd_irq), .pre_irq(pre_irq),
    .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic tk(input int k);
    ref_tick = 1'b1;
    repeat (k) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    logic [31:0] v, a0, b0;
    int hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 status", v, 0);
    rd(8'h1C, v); chk("R1 pre count", v, 0);
    rd(8'h34, v); chk("R1 wd count", v, 0);
    rd(8'h40, v); chk("R1 rsten", v, 0);
    rd(8'h44, v); chk("R1 rstmask", v, 0);
    chk("R1 outputs", {29'd0, wd_irq, pre_irq, rst_req}, 0);

    // R2 field layout
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 ctrl mask", v, 32'h000F_1504);
    wr(8'h00, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R2 rsten", v, 32'h100);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk("R2 rstmask", v, 32'h400);
    wr(8'h40, 0); wr(8'h44, 0);
    rd(8'h08, v); chk("R2 unmapped", v, 0);

    // R3 full width load
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, v); chk("R3 max load", v, 32'hFFFF_FFFF);
    wr(8'h00, 32'h500); tk(1); rd(8'h34, v); chk("R3 max dec", v, 32'hFFFF_FFFE);
    wr(8'h00, 0);

    // R3 R4 watchdog sweep over load values
    for (int n = 1; n <= 8; n++) begin
      wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h34, n); wr(8'h00, 32'h500);
      for (int k = 0; k <= n + 1; k++) begin
        rd(8'h34, v); chk("R3 wd count", v, (k < n) ? n - k : 0);
        chk("R4 wd irq", {31'd0, wd_irq}, (k >= n) ? 1 : 0);
        chk("R6 pre untouched", {31'd0, pre_irq}, 0);
        tk(1);
      end
      rd(8'h04, v); chk("R4 status wd", v, 32'h8000_0000);
    end

    // R5 write-zero-to-clear
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R5 write ones keep", v, 32'h8000_0000);
    wr(8'h00, 0);

    // R4 R6 pretimeout sweep
    for (int n = 1; n <= 8; n++) begin
      wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h1C, n); wr(8'h00, 32'h1004);
      for (int k = 0; k <= n + 1; k++) begin
        rd(8'h1C, v); chk("R6 pre count", v, (k < n) ? n - k : 0);
        chk("R6 pre irq", {31'd0, pre_irq}, (k >= n) ? 1 : 0);
        chk("R6 wd untouched", {31'd0, wd_irq}, 0);
        tk(1);
      end
    end
    wr(8'h00, 0);

    // R6 both running, pretimeout first
    wr(8'h04, 0); wr(8'h34, 6); wr(8'h1C, 3); wr(8'h00, 32'h1504);
    tk(3);
    chk("R6 pre first", {30'd0, wd_irq, pre_irq}, 32'h1);
    rd(8'h34, v); chk("R6 wd still running", v, 3);
    tk(3);
    chk("R6 both expired", {30'd0, wd_irq, pre_irq}, 32'h3);
    // R5 bit-selective clear
    wr(8'h04, 32'h7FFF_FFFF); rd(8'h04, v); chk("R5 clear wd only", v, 32'h100);
    wr(8'h04, 32'hFFFF_FEFF); rd(8'h04, v); chk("R5 clear pre only", v, 0);

    // R3 freeze when disabled
    wr(8'h34, 6); wr(8'h00, 32'h400); tk(5);
    rd(8'h34, v); chk("R3 freeze", v, 6);

    // R9 write wins over tick
    wr(8'h00, 32'h500);
    ref_tick = 1'b1; wr(8'h34, 7); ref_tick = 1'b0;
    rd(8'h34, v); chk("R9 write priority", v, 7);
    tk(1); rd(8'h34, v); chk("R9 then decrement", v, 6);
    wr(8'h00, 0);

    // R7 R8 reset gating and pulse length
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h40, (c & 1) ? 32'h100 : 0);
      wr(8'h44, (c & 2) ? 32'h400 : 0);
      wr(8'h34, 2); wr(8'h00, 32'h500);
      tk(2);
      hi = 0;
      for (int i = 0; i < 40; i++) begin
        if (rst_req) hi++;
        @(negedge clk);
      end
      chk("R7 R8 pulse cycles", hi, (c == 1) ? 16 : 0);
      hi = 0;
      ref_tick = 1'b1;
      for (int i = 0; i < 20; i++) begin
        if (rst_req) hi++;
        @(negedge clk);
      end
      ref_tick = 1'b0;
      chk("R8 no repeat pulse", hi, 0);
    end
    // R7 watchdog disabled blocks reset
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h44, 0); wr(8'h40, 32'h100);
    wr(8'h34, 1); wr(8'h04, 0); tk(3);
    chk("R7 disabled no reset", {31'd0, rst_req}, 0);
    wr(8'h40, 0);

    // R10 prescaler
    wr(8'h00, 0); wr(8'h34, 1000); wr(8'h00, 32'h0005_0100);
    addr = 8'h34; @(negedge clk); a0 = rdata;
    repeat (320) @(negedge clk); b0 = rdata;
    chk("R10 exp5 divide", a0 - b0, 10);
    wr(8'h00, 0); wr(8'h34, 1000); wr(8'h00, 32'h100);
    addr = 8'h34; @(negedge clk); a0 = rdata;
    repeat (20) @(negedge clk); b0 = rdata;
    chk("R10 exp0 every cycle", a0 - b0, 20);

    // R11 source select
    wr(8'h00, 0); wr(8'h1C, 500); wr(8'h00, 32'h1004);
    addr = 8'h1C; @(negedge clk); a0 = rdata;
    repeat (50) @(negedge clk); b0 = rdata;
    chk("R11 ref select ignores prescaler", a0 - b0, 0);
    wr(8'h00, 32'h4);
    addr = 8'h1C; @(negedge clk); a0 = rdata;
    repeat (50) @(negedge clk); b0 = rdata;
    chk("R11 prescaler counts", a0 - b0, 50);
    wr(8'h00, 32'h400); wr(8'h34, 9); tk(4);
    rd(8'h34, v); chk("R11 ref tick disabled wd", v, 9);
    wr(8'h00, 32'h0000_F500); tk(4);
    rd(8'h34, v); chk("R11 ref ticks counted", v, 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule